// File: doc/BRIEF.md
# Reordering Corrected-Block Output Formatter

This block is the output stage of a block error-correction decoder. The correction core hands it each processed block one byte per clock, last byte of the block first, and gives a correction vector with every byte. The formatter keeps the bytes in a circular buffer and hands them to the system through an active-low ready/strobe handshake. The block can leave in the order it first arrived at the decoder (forward) or in the order the core produced it (reverse).

Each output byte is one of four things: the correction vector, the corrected byte, the raw byte, or zero. Check bytes can be left out of the output. A flag marks every byte that needed a correction. A correctability indication is driven only while the final byte of a block is offered. Storage is given back while the reader moves along, so the next block can be written while the current one is still being read.

Top module: `fmt_out_stage`

## Requirements
- R1: After reset, `out_rdy_n` and `out_crt_n` are 1, `out_err` is 0, `out_data` is 0 and `core_wr_ready` is 1.
- R2: In reverse order (`cfg_fwd`=0) bytes leave in the order the core wrote them. The last check byte comes first and the first message byte comes last. A byte is offered from the cycle after it was written.
- R3: In forward order (`cfg_fwd`=1) the block leaves in its original order, first message byte first. `out_rdy_n` stays 1 until all `cfg_blk_len` bytes of the block are stored.
- R4: The content select is {`cfg_raw`,`cfg_corr`}. 00 gives the vector, 01 gives raw XOR vector, 10 gives 0x00 and 11 gives the raw byte.
- R5: With `cfg_nopar`=1 and `cfg_raw`=0 the `cfg_chk_cnt` check bytes are not output: the last R bytes in forward order, the first R in reverse order. With `cfg_raw`=1, `cfg_nopar` and `cfg_chk_cnt` have no effect and all N bytes are output.
- R6: The read position advances only at a rising edge where `out_rdy_n`=0 and `out_stb_n`=0; a strobe at any other time is ignored. While `out_rdy_n`=1, `out_data` is 0x00.
- R7: `out_err` is 1 exactly while a byte is offered whose vector is nonzero and `cfg_raw`=0.
- R8: `out_crt_n` is 0 only while the final output byte of a block is offered and the block is correctable, otherwise 1. A block is uncorrectable if `core_blk_fail` was 1, or if `core_ers_over` was 1 while `cfg_erc`=0. Both inputs are sampled with the block's last write.
- R9: `core_wr_ready` is 1 while fewer than DEPTH (256) buffer entries are unreleased and fewer than STAT_DEPTH completed blocks wait. In reverse order each strobed byte releases its entry at once. In forward order the whole block is released at its final strobe.
- R10: Consecutive blocks are delivered in the order they were written, each with its own correctability.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_blk_len | input | 8 | Block length N (3..255) |
| cfg_chk_cnt | input | 5 | Check bytes per block R (2..20) |
| cfg_fwd | input | 1 | 1 = forward order, 0 = reverse order |
| cfg_nopar | input | 1 | 1 = leave check bytes out |
| cfg_corr | input | 1 | Content select low bit |
| cfg_raw | input | 1 | Content select high bit |
| cfg_erc | input | 1 | Erasure-overflow alone does not mark a block uncorrectable |
| core_wr_en | input | 1 | Core offers a byte |
| core_raw | input | 8 | Uncorrected byte |
| core_vec | input | 8 | Correction vector for that byte |
| core_blk_fail | input | 1 | Block not correctable (sampled on last write) |
| core_ers_over | input | 1 | Erasure count exceeded limit (sampled on last write) |
| core_wr_ready | output | 1 | Buffer can take a write this cycle |
| out_rdy_n | output | 1 | Active low: a byte is offered |
| out_stb_n | input | 1 | Active low: system takes the offered byte |
| out_data | output | 8 | Output byte |
| out_err | output | 1 | Offered byte carries a correction |
| out_crt_n | output | 1 | Active low: block correctable (final byte only) |

## Verification
The bound checker checks on every cycle the properties that hold at each clock edge. The buffer never holds more than DEPTH unreleased entries. Forward order never offers a byte before the whole block is stored. The read position holds when no strobe is taken. The bus, the error flag and the correctability output are quiet while nothing is offered. The correctability output appears only on the final byte, and the zero and vector content modes keep their meaning. The byte order, the dropped check bytes, the per-block correctability and the recovery of buffer space for overlapped blocks can only be shown by the bench. It runs scenarios that compare every delivered byte with a sequence computed from the block's contents.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 8;
  localparam int CHK_W  = 5;

  typedef enum logic [1:0] {
    SEL_VEC  = 2'b00,
    SEL_FIX  = 2'b01,
    SEL_ZERO = 2'b10,
    SEL_RAW  = 2'b11
  } sel_e;

  typedef struct packed {
    logic [BYTE_W-1:0] raw;
    logic [BYTE_W-1:0] vec;
  } cell_t;

  // number of bytes that leave the block
  function automatic logic [LEN_W-1:0] out_len(input logic [LEN_W-1:0] n,
                                               input logic [CHK_W-1:0] r,
                                               input logic drop);
    return drop ? n - LEN_W'(r) : n;
  endfunction

  // buffer offset (write order) of output index j
  function automatic logic [LEN_W-1:0] rd_offset(input logic fwd,
                                                 input logic [LEN_W-1:0] n,
                                                 input logic [LEN_W-1:0] j,
                                                 input logic [LEN_W-1:0] skip);
    return fwd ? n - 8'd1 - j : j + skip;
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input sel_e s,
                                                  input logic [BYTE_W-1:0] raw,
                                                  input logic [BYTE_W-1:0] vec);
    case (s)
      SEL_VEC:  return vec;
      SEL_FIX:  return raw ^ vec;
      SEL_ZERO: return '0;
      default:  return raw;
    endcase
  endfunction

  function automatic logic blk_ok(input logic fail, input logic ers, input logic erc);
    return !(fail || (ers && !erc));
  endfunction
endpackage

// File: rtl/fmt_store.sv
module fmt_store
  import fmt_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  cell_t            wr_cell,
  input  logic [LEN_W-1:0] blk_len,
  output logic             wr_blk_end,
  input  logic [AW-1:0]    rd_addr,
  output cell_t            rd_cell
);
  cell_t            mem [DEPTH];
  logic [AW-1:0]    wp;
  logic [LEN_W-1:0] wcnt;

  assign wr_blk_end = wr_fire && (wcnt == blk_len - 8'd1);
  assign rd_cell    = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wp] <= wr_cell;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      wcnt <= '0;
    end else if (wr_fire) begin
      wp   <= wp + AW'(1);
      wcnt <= wr_blk_end ? '0 : wcnt + 8'd1;
    end
  end
endmodule

// File: rtl/fmt_stat_fifo.sv
module fmt_stat_fifo #(
  parameter int SD = 4,
  localparam int PW = $clog2(SD),
  localparam int CW = $clog2(SD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_ok,
  input  logic          pop,
  output logic          head_ok,
  output logic [CW-1:0] count
);
  logic [SD-1:0] okbits;
  logic [PW-1:0] wp, rp;

  assign head_ok = okbits[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      okbits <= '0;
      wp     <= '0;
      rp     <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        okbits[wp] <= push_ok;
        wp         <= (wp == PW'(SD - 1)) ? '0 : wp + PW'(1);
      end
      if (pop) rp <= (rp == PW'(SD - 1)) ? '0 : rp + PW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/fmt_reader.sv
module fmt_reader
  import fmt_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [CHK_W-1:0] chk_cnt,
  input  logic             fwd,
  input  logic             drop,
  input  logic             wr_fire,
  input  logic             stb_n,
  output logic [AW-1:0]    rd_addr,
  output logic             rdy,
  output logic             at_last,
  output logic             rd_fire,
  output logic             blk_whole,
  output logic [LEN_W-1:0] idx,
  output logic [CW-1:0]    occ
);
  logic [AW-1:0]    base;
  logic [CW-1:0]    since_base;
  logic [LEN_W-1:0] len, skip, offset;
  logic [CW-1:0]    rel, retire;

  assign len       = out_len(blk_len, chk_cnt, drop);
  assign skip      = drop ? LEN_W'(chk_cnt) : '0;
  assign offset    = rd_offset(fwd, blk_len, idx, skip);
  assign rd_addr   = base + AW'(offset);
  assign blk_whole = since_base >= CW'(blk_len);
  assign rdy       = fwd ? blk_whole : (since_base > CW'(offset));
  assign at_last   = idx == len - 8'd1;
  assign rd_fire   = rdy && !stb_n;

  always_comb begin
    rel    = '0;
    retire = '0;
    if (rd_fire) begin
      rel = CW'(!fwd);
      if (at_last) begin
        rel    = rel + (fwd ? CW'(blk_len) : CW'(blk_len - len));
        retire = CW'(blk_len);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base       <= '0;
      idx        <= '0;
      occ        <= '0;
      since_base <= '0;
    end else begin
      occ        <= occ + CW'(wr_fire) - rel;
      since_base <= since_base + CW'(wr_fire) - retire;
      if (rd_fire) begin
        if (at_last) begin
          idx  <= '0;
          base <= base + AW'(blk_len);
        end else begin
          idx <= idx + 8'd1;
        end
      end
    end
  end
endmodule

// File: rtl/fmt_out_stage.sv
module fmt_out_stage
  import fmt_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int STAT_DEPTH = 4,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int SCW = $clog2(STAT_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_blk_len,
  input  logic [CHK_W-1:0]  cfg_chk_cnt,
  input  logic              cfg_fwd,
  input  logic              cfg_nopar,
  input  logic              cfg_corr,
  input  logic              cfg_raw,
  input  logic              cfg_erc,
  input  logic              core_wr_en,
  input  logic [BYTE_W-1:0] core_raw,
  input  logic [BYTE_W-1:0] core_vec,
  input  logic              core_blk_fail,
  input  logic              core_ers_over,
  output logic              core_wr_ready,
  output logic              out_rdy_n,
  input  logic              out_stb_n,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_err,
  output logic              out_crt_n
);
  // named internal events, also used by the bound checker
  logic             ev_wr_fire;
  logic             ev_blk_end;
  logic             ev_rd_fire;
  logic             ev_at_last;
  logic             ev_blk_whole;
  logic             ev_rdy;
  logic [LEN_W-1:0] ev_idx;
  logic [CW-1:0]    ev_occ;
  logic [SCW-1:0]   stat_cnt;
  logic             head_ok;
  logic [AW-1:0]    rd_addr;
  cell_t            rd_cell;
  cell_t            wr_cell;
  logic             drop;
  sel_e             sel;

  assign drop          = cfg_nopar && !cfg_raw;
  assign sel           = sel_e'({cfg_raw, cfg_corr});
  assign core_wr_ready = (ev_occ < CW'(DEPTH)) && (stat_cnt < SCW'(STAT_DEPTH));
  assign ev_wr_fire    = core_wr_en && core_wr_ready;
  assign wr_cell       = '{raw: core_raw, vec: core_vec};

  fmt_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_fire(ev_wr_fire), .wr_cell(wr_cell),
    .blk_len(cfg_blk_len), .wr_blk_end(ev_blk_end),
    .rd_addr(rd_addr), .rd_cell(rd_cell)
  );

  fmt_stat_fifo #(.SD(STAT_DEPTH)) u_stat (
    .clk(clk), .rst_n(rst_n), .push(ev_blk_end),
    .push_ok(blk_ok(core_blk_fail, core_ers_over, cfg_erc)),
    .pop(ev_rd_fire && ev_at_last), .head_ok(head_ok), .count(stat_cnt)
  );

  fmt_reader #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .blk_len(cfg_blk_len), .chk_cnt(cfg_chk_cnt),
    .fwd(cfg_fwd), .drop(drop), .wr_fire(ev_wr_fire), .stb_n(out_stb_n),
    .rd_addr(rd_addr), .rdy(ev_rdy), .at_last(ev_at_last), .rd_fire(ev_rd_fire),
    .blk_whole(ev_blk_whole), .idx(ev_idx), .occ(ev_occ)
  );

  assign out_rdy_n = !ev_rdy;
  assign out_data  = ev_rdy ? pick_byte(sel, rd_cell.raw, rd_cell.vec) : '0;
  assign out_err   = ev_rdy && !cfg_raw && (rd_cell.vec != '0);
  assign out_crt_n = !(ev_rdy && ev_at_last && head_ok);
endmodule

// File: rtl/fmt_out_checker.sv
module fmt_out_checker #(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_fwd,
  input logic          cfg_corr,
  input logic          cfg_raw,
  input logic          out_rdy_n,
  input logic          out_stb_n,
  input logic [7:0]    out_data,
  input logic          out_err,
  input logic          out_crt_n,
  input logic          ev_at_last,
  input logic          ev_blk_whole,
  input logic [7:0]    ev_idx,
  input logic [CW-1:0] ev_occ
);
  assert_occ_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_occ <= CW'(DEPTH));

  assert_fwd_whole_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_rdy_n && cfg_fwd) |-> ev_blk_whole);

  assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb_n || out_rdy_n) |=> $stable(ev_idx));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_rdy_n |-> (out_data == 8'h00 && !out_err && out_crt_n));

  assert_crt_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_crt_n |-> (!out_rdy_n && ev_at_last));

  assert_err_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_err && !cfg_corr && !cfg_raw) |-> out_data != 8'h00);

  assert_zero_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_rdy_n && cfg_raw && !cfg_corr) |-> out_data == 8'h00);
endmodule

bind fmt_out_stage fmt_out_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_fwd(cfg_fwd), .cfg_corr(cfg_corr),
  .cfg_raw(cfg_raw), .out_rdy_n(out_rdy_n), .out_stb_n(out_stb_n),
  .out_data(out_data), .out_err(out_err), .out_crt_n(out_crt_n),
  .ev_at_last(ev_at_last), .ev_blk_whole(ev_blk_whole), .ev_idx(ev_idx),
  .ev_occ(ev_occ)
);

// File: tb/tb_fmt_out_stage.sv
module tb_fmt_out_stage;
  logic clk = 0, rst_n = 0;
  logic [7:0] cfg_blk_len = 8'd10;
  logic [4:0] cfg_chk_cnt = 5'd2;
  logic cfg_fwd = 0, cfg_nopar = 0, cfg_corr = 0, cfg_raw = 0, cfg_erc = 0;
  logic core_wr_en = 0, core_blk_fail = 0, core_ers_over = 0;
  logic [7:0] core_raw = 0, core_vec = 0;
  logic core_wr_ready, out_rdy_n, out_err, out_crt_n;
  logic out_stb_n = 1;
  logic [7:0] out_data;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fmt_out_stage dut (.*);

  // fields: fwd nopar corr raw erc fail ers | N[7:0] | R[4:0]
  localparam logic [19:0] TABLE [8] = '{
    {7'b0000000, 8'd10,  5'd4},
    {7'b1010001, 8'd12,  5'd2},
    {7'b0110101, 8'd9,   5'd3},
    {7'b1100010, 8'd7,   5'd2},
    {7'b0111000, 8'd6,   5'd2},
    {7'b1101000, 8'd5,   5'd2},
    {7'b0000111, 8'd3,   5'd2},
    {7'b1010000, 8'd255, 5'd20}
  };

  function automatic logic [7:0] raw_of(int p, int seed);
    return 8'(p * 7 + seed * 29 + 3);
  endfunction
  function automatic logic [7:0] vec_of(int p, int seed);
    return ((p + seed) % 3 == 0) ? (8'h80 | 8'(p)) : 8'h00;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(bit fwd, bit nopar, bit corr, bit raw, bit erc, int n, int r);
    cfg_fwd = fwd; cfg_nopar = nopar; cfg_corr = corr; cfg_raw = raw; cfg_erc = erc;
    cfg_blk_len = 8'(n); cfg_chk_cnt = 5'(r);
  endtask

  // entered and left at a falling edge
  task automatic put_byte(int p, int seed, bit fail, bit ers);
    int guard = 0;
    while (!core_wr_ready && guard < 1000) begin @(negedge clk); guard++; end
    core_wr_en = 1; core_raw = raw_of(p, seed); core_vec = vec_of(p, seed);
    core_blk_fail = fail; core_ers_over = ers;
    @(negedge clk);
    core_wr_en = 0;
  endtask

  task automatic write_block(int n, int seed, bit fail, bit ers);
    for (int p = n - 1; p >= 0; p--) put_byte(p, seed, fail, ers);
  endtask

  task automatic read_byte(int j, int n, int r, int seed, bit ok, string tag);
    int guard = 0;
    bit drop = cfg_nopar && !cfg_raw;
    int len = drop ? n - r : n;
    int p = cfg_fwd ? j : (drop ? n - r - 1 - j : n - 1 - j);
    logic [7:0] rw = raw_of(p, seed), vc = vec_of(p, seed), ex;
    while (out_rdy_n && guard < 1000) begin @(negedge clk); guard++; end
    case ({cfg_raw, cfg_corr})
      2'b00: ex = vc;
      2'b01: ex = rw ^ vc;
      2'b10: ex = 8'h00;
      default: ex = rw;
    endcase
    check(out_rdy_n == 0, {tag, " ready"}, out_rdy_n, 0);
    check(out_data == ex, {tag, "/R4 data"}, out_data, ex);
    check(out_err == (!cfg_raw && vc != 0), "R7 err", out_err, !cfg_raw && vc != 0);
    check(out_crt_n == !(j == len - 1 && ok), "R8 crt", out_crt_n, !(j == len - 1 && ok));
    out_stb_n = 0;
    @(negedge clk);
    out_stb_n = 1;
  endtask

  task automatic read_block(int j0, int n, int r, int seed, bit ok, string tag);
    int len = (cfg_nopar && !cfg_raw) ? n - r : n;
    for (int j = j0; j < len; j++) read_byte(j, n, r, seed, ok, tag);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_rdy_n == 1, "R1 rdy_n", out_rdy_n, 1);
    check(out_crt_n == 1, "R1 crt_n", out_crt_n, 1);
    check(out_err == 0, "R1 err", out_err, 0);
    check(out_data == 0, "R1 data", out_data, 0);
    check(core_wr_ready == 1, "R1 wr_ready", core_wr_ready, 1);
    rst_n = 1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < 8; i++) begin
      logic [19:0] e = TABLE[i];
      bit ok = !(e[14] || (e[13] && !e[15]));
      string tag;
      set_cfg(e[19], e[18], e[17], e[16], e[15], int'(e[12:5]), int'(e[4:0]));
      if (e[18] && !e[16]) tag = "R5";
      else if (e[16] && e[18]) tag = "R5 raw";
      else tag = e[19] ? "R3" : "R2";
      write_block(int'(e[12:5]), i, e[14], e[13]);
      read_block(0, int'(e[12:5]), int'(e[4:0]), i, ok, tag);
      check(out_rdy_n == 1, "R6 idle after block", out_rdy_n, 1);
      check(out_data == 0, "R6 idle data", out_data, 0);
    end

    // R6: strobe while not ready is ignored; R2: byte offered after one write
    set_cfg(0, 0, 1, 0, 0, 5, 2);
    out_stb_n = 0;
    repeat (3) @(negedge clk);
    out_stb_n = 1;
    put_byte(4, 40, 0, 0);
    check(out_rdy_n == 0, "R2 early offer", out_rdy_n, 0);
    check(out_data == (raw_of(4, 40) ^ vec_of(4, 40)), "R6 index kept", out_data,
          raw_of(4, 40) ^ vec_of(4, 40));
    for (int p = 3; p >= 0; p--) put_byte(p, 40, 0, 0);
    read_block(0, 5, 2, 40, 1, "R6");

    // R3: forward waits for the whole block
    set_cfg(1, 0, 0, 1, 0, 6, 2);
    for (int p = 5; p >= 1; p--) put_byte(p, 41, 0, 0);
    check(out_rdy_n == 1, "R3 wait", out_rdy_n, 1);
    put_byte(0, 41, 0, 0);
    check(out_rdy_n == 0, "R3 whole", out_rdy_n, 0);
    read_block(0, 6, 2, 41, 1, "R3");

    // R9/R10: fill the buffer with two blocks, release one entry, drain in order
    set_cfg(0, 0, 1, 0, 0, 128, 4);
    write_block(128, 50, 0, 0);
    write_block(128, 51, 1, 0);
    check(core_wr_ready == 0, "R9 full", core_wr_ready, 0);
    read_byte(0, 128, 4, 50, 1, "R9");
    check(core_wr_ready == 1, "R9 released", core_wr_ready, 1);
    read_block(1, 128, 4, 50, 1, "R10 first");
    read_block(0, 128, 4, 51, 0, "R10 second");
    check(out_crt_n == 1, "R8 idle crt", out_crt_n, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule